// File: doc/BRIEF.md
# Ring Buffer Burst Write Controller

The block accepts a stream of 32-bit words from an image capture path and turns it into write bursts aimed at a circular buffer in system memory. Words are grouped into bursts of up to eight beats. Each burst is announced on a command channel with a start address and a beat count, and its beats are then delivered on a separate data channel. The write address runs from the buffer base to its end and then starts again at the base. A software-maintained read pointer tells the block how much of the buffer has been consumed.

The block never overwrites unread data. Before it opens a new burst group it checks three things: at least 32 bytes of free ring space, a free burst slot, and room in the staging store. If any is missing, the word is discarded and a one-cycle data-loss pulse is raised. The block then keeps discarding until the next frame start, so no torn frame is stored. At frame end a partly filled group is sent as a shorter burst. A group also closes early when it reaches the end of the buffer, so no burst ever crosses the wrap point.

The input side is one state machine with three states:
- `IN_IDLE`: no group is open.
- `IN_FILL`: a group is collecting words.
- `IN_DROP`: the block is discarding until a frame start.

Its transitions are:
- `IN_IDLE`→`IN_FILL`: a word is accepted and the group stays open.
- `IN_FILL`→`IN_IDLE`: the group closes at eight words, at the buffer end, or at frame end.
- `IN_IDLE`→`IN_DROP`: a word arrives with no room.
- `IN_DROP`→`IN_IDLE`: frame start.

Top module: `rbuf_burst_wr`

## Requirements
- R1: After reset, `cmd_valid`, `wr_valid`, `loss_irq` and `buf_full` are 0 (with a non-empty buffer and `rd_ptr` equal to 0) and `wr_ptr` is 0.
- R2: Eight consecutive accepted words form one command with `cmd_len` = 8 at address `cfg_base` + write offset. Its beats carry the words in arrival order, and `wr_last` is 1 only on the eighth beat. A command is held stable until acknowledged.
- R3: A `frame_end` pulse with an open group of n words (1..7) issues a command with `cmd_len` = n. The committed pointer then advances by 4·n bytes.
- R4: A group closes when its last word fills the final 4 bytes of the buffer. The next command addresses `cfg_base`. `wr_ptr` bit OFF_W (the lap bit) toggles and its low OFF_W bits restart from 0.
- R5: At most MAX_OUT (2) commands are acknowledged ahead of the completion of their data. No beat is sent while `wr_ready` is 0.
- R6: `buf_full` is 1 exactly when fewer than 32 bytes are free. Free space is `cfg_size` minus the used space between the reserve pointer and `rd_ptr`. Both pointers carry a lap bit at bit OFF_W; equal lap bits mean used = write − read, and different lap bits mean used = size − read + write.
- R7: A word arriving when no group is open is discarded if the ring is full, both burst slots are busy, or the staging store has fewer than eight free words. In that case `loss_irq` is 1 for the single cycle after that word and no command results.
- R8: After a discard, further words are dropped without another `loss_irq` pulse until `frame_start`. Words after `frame_start` are accepted again.
- R9: `wr_ptr` advances by 4 bytes on each beat handshake (`wr_valid` and `wr_ready`), so it counts only bytes actually written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | ADDR_W | Buffer base address, multiple of 32 |
| cfg_size | input | OFF_W+1 | Buffer size in bytes, multiple of 32, at most 2^OFF_W |
| rd_ptr | input | OFF_W+1 | Software read pointer: lap bit and byte offset |
| frame_start | input | 1 | Frame start pulse |
| frame_end | input | 1 | Frame end pulse, flushes an open group |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| cmd_valid | output | 1 | Burst command request |
| cmd_ack | input | 1 | Burst command accepted |
| cmd_addr | output | ADDR_W | Burst start byte address |
| cmd_len | output | LEN_W | Beats in the burst, 1..BEATS |
| wr_valid | output | 1 | Data beat present |
| wr_ready | input | 1 | Memory takes the beat |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of a burst |
| wr_ptr | output | OFF_W+1 | Committed write pointer: lap bit and byte offset |
| buf_full | output | 1 | Fewer than 32 bytes free |
| loss_irq | output | 1 | Data-loss pulse |

## Verification
The bench builds the block with OFF_W = 8, BEATS = 8 and MAX_OUT = 2. It drives a 96-byte buffer, three bursts long, so wrap-around, lap-bit toggling and ring-full refusal are all reached within a few dozen words. Holding `wr_ready` low while acknowledging commands fills both burst slots, which brings the outstanding limit and the slot-busy discard within reach. Moving the read pointer by hand then shows the full flag clearing and capture resuming.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
    typedef enum logic [1:0] {
        IN_IDLE = 2'd0,
        IN_FILL = 2'd1,
        IN_DROP = 2'd2
    } in_state_t;
endpackage

// File: rtl/rbw_ring_ptr.sv
module rbw_ring_ptr #(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [OFF_W:0]   size,
    output logic [OFF_W-1:0] off,
    output logic             lap,
    output logic             at_end
);
    logic [OFF_W:0] nxt;

    assign nxt    = {1'b0, off} + (OFF_W+1)'(4);
    assign at_end = (nxt == size);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off <= '0;
            lap <= 1'b0;
        end else if (adv) begin
            if (at_end) begin
                off <= '0;
                lap <= ~lap;
            end else begin
                off <= nxt[OFF_W-1:0];
            end
        end
    end

    // R4: a wrap sends the offset back to zero and flips the lap bit
    a_r4_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_end) |=> (off == '0) && (lap != $past(lap)));
endmodule

// File: rtl/rbw_stage_fifo.sv
module rbw_stage_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] free_cnt
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] wi, ri;
    logic [CW-1:0] cnt;

    function automatic logic [IW-1:0] inc(input logic [IW-1:0] v);
        return (v == IW'(DEPTH-1)) ? '0 : v + 1'b1;
    endfunction

    assign dout     = mem[ri];
    assign free_cnt = CW'(DEPTH) - cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wi] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wi  <= '0;
            ri  <= '0;
            cnt <= '0;
        end else begin
            if (push) wi <= inc(wi);
            if (pop)  ri <= inc(ri);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt != CW'(DEPTH)) || pop);
    a_r9_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
endmodule

// File: rtl/rbuf_burst_wr.sv
module rbuf_burst_wr
    import rbw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int BEATS   = 8,
    parameter int MAX_OUT = 2,
    localparam int LEN_W  = $clog2(BEATS+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [OFF_W:0]    cfg_size,
    input  logic [OFF_W:0]    rd_ptr,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              cmd_valid,
    input  logic              cmd_ack,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [31:0]       wr_data,
    output logic              wr_last,
    output logic [OFF_W:0]    wr_ptr,
    output logic              buf_full,
    output logic              loss_irq
);
    localparam int BURST_B = BEATS * 4;
    localparam int FIFO_D  = MAX_OUT * BEATS;
    localparam int FC_W    = $clog2(FIFO_D+1);
    localparam int SLOT_W  = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
    localparam int CNT_W   = $clog2(MAX_OUT+1);

    in_state_t st, st_nx;

    logic [OFF_W-1:0] res_off, com_off, cmd_off;
    logic             res_lap, com_lap, res_end, com_end;
    logic [OFF_W:0]   used, free_b;
    logic [FC_W-1:0]  fifo_free;
    logic [LEN_W-1:0] open_len, len_nx, beat;
    logic [LEN_W-1:0] lens [MAX_OUT];
    logic [SLOT_W-1:0] tq, cq, dq;
    logic [CNT_W-1:0] n_closed, n_cmd;
    logic accept, refuse, close, room, cmd_hs, beat_hs, last_hs;

    function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] v);
        return (v == SLOT_W'(MAX_OUT-1)) ? '0 : v + 1'b1;
    endfunction

    // reserve pointer: one step per accepted word
    rbw_ring_ptr #(.OFF_W(OFF_W)) u_res (
        .clk(clk), .rst_n(rst_n), .adv(accept), .size(cfg_size),
        .off(res_off), .lap(res_lap), .at_end(res_end));

    // committed pointer: one step per written beat
    rbw_ring_ptr #(.OFF_W(OFF_W)) u_com (
        .clk(clk), .rst_n(rst_n), .adv(beat_hs), .size(cfg_size),
        .off(com_off), .lap(com_lap), .at_end(com_end));

    rbw_stage_fifo #(.W(32), .DEPTH(FIFO_D)) u_stage (
        .clk(clk), .rst_n(rst_n), .push(accept), .din(in_data),
        .pop(beat_hs), .dout(wr_data), .free_cnt(fifo_free));

    // free space against the software read pointer
    always_comb begin
        if (res_lap == rd_ptr[OFF_W])
            used = {1'b0, res_off} - {1'b0, rd_ptr[OFF_W-1:0]};
        else
            used = cfg_size - {1'b0, rd_ptr[OFF_W-1:0]} + {1'b0, res_off};
        free_b = cfg_size - used;
    end

    assign buf_full = (free_b < (OFF_W+1)'(BURST_B));
    assign room     = !buf_full && (n_closed < CNT_W'(MAX_OUT))
                      && (fifo_free >= FC_W'(BEATS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IN_IDLE;
        else        st <= st_nx;
    end

    // next state and strobes
    always_comb begin
        accept = 1'b0;
        refuse = 1'b0;
        st_nx  = st;
        unique case (st)
            IN_IDLE: begin
                if (in_valid) begin
                    if (room) accept = 1'b1;
                    else      refuse = 1'b1;
                end
            end
            IN_FILL: accept = in_valid;
            IN_DROP: if (frame_start) st_nx = IN_IDLE;
            default: st_nx = IN_IDLE;
        endcase
        len_nx = open_len + LEN_W'(accept);
        close  = (st != IN_DROP) &&
                 ((accept && (len_nx == LEN_W'(BEATS) || res_end)) ||
                  (frame_end && len_nx != '0));
        if (refuse)                 st_nx = IN_DROP;
        else if (st != IN_DROP)     st_nx = (close || len_nx == '0) ? IN_IDLE : IN_FILL;
    end

    // command and data channels
    assign cmd_valid = (n_closed != n_cmd) && (n_cmd < CNT_W'(MAX_OUT));
    assign cmd_len   = lens[cq];
    assign cmd_addr  = cfg_base + ADDR_W'(cmd_off);
    assign cmd_hs    = cmd_valid && cmd_ack;
    assign wr_valid  = (n_cmd != '0);
    assign wr_last   = (beat == lens[dq] - 1'b1);
    assign beat_hs   = wr_valid && wr_ready;
    assign last_hs   = beat_hs && wr_last;
    assign wr_ptr    = {com_lap, com_off};

    logic [OFF_W:0] cmd_nx;
    assign cmd_nx = {1'b0, cmd_off} + (OFF_W+1)'({cmd_len, 2'b00});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_len <= '0;
            tq       <= '0;
            cq       <= '0;
            dq       <= '0;
            n_closed <= '0;
            n_cmd    <= '0;
            beat     <= '0;
            cmd_off  <= '0;
            loss_irq <= 1'b0;
            for (int i = 0; i < MAX_OUT; i++) lens[i] <= '0;
        end else begin
            loss_irq <= refuse;
            open_len <= close ? '0 : len_nx;
            if (close) begin
                lens[tq] <= len_nx;
                tq       <= slot_inc(tq);
            end
            if (cmd_hs) begin
                cq      <= slot_inc(cq);
                cmd_off <= (cmd_nx == cfg_size) ? '0 : cmd_nx[OFF_W-1:0];
            end
            if (beat_hs) begin
                if (wr_last) begin
                    beat <= '0;
                    dq   <= slot_inc(dq);
                end else begin
                    beat <= beat + 1'b1;
                end
            end
            n_closed <= n_closed + CNT_W'(close) - CNT_W'(last_hs);
            n_cmd    <= n_cmd + CNT_W'(cmd_hs) - CNT_W'(last_hs);
        end
    end

    a_r5_out_limit: assert property (@(posedge clk) disable iff (!rst_n)
        n_cmd <= CNT_W'(MAX_OUT));
    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0) && (cmd_len <= LEN_W'(BEATS)));
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));
    a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_nx <= cfg_size));
    a_r7_loss_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        loss_irq |=> !loss_irq);
    a_r8_drop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_DROP) |-> !accept);
endmodule

// File: tb/sim_rbuf_burst_wr.sv
module sim_rbuf_burst_wr;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 8;
    localparam int LEN_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = 32'h1000;
    logic [OFF_W:0]    cfg_size = 9'd96;
    logic [OFF_W:0]    rd_ptr = '0;
    logic frame_start = 1'b0, frame_end = 1'b0, in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic cmd_valid, cmd_ack = 1'b1, wr_valid, wr_ready = 1'b1, wr_last;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic [31:0]       wr_data;
    logic [OFF_W:0]    wr_ptr;
    logic buf_full, loss_irq;

    int n_chk = 0, n_bad = 0;
    int n_cmds = 0, n_beats = 0;
    logic [ADDR_W-1:0] log_addr [64];
    logic [LEN_W-1:0]  log_len  [64];
    logic [31:0]       log_data [256];
    logic              log_last [256];

    always #10 clk = ~clk;

    rbuf_burst_wr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEATS(8), .MAX_OUT(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .rd_ptr(rd_ptr), .frame_start(frame_start), .frame_end(frame_end),
        .in_valid(in_valid), .in_data(in_data), .cmd_valid(cmd_valid),
        .cmd_ack(cmd_ack), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_last(wr_last), .wr_ptr(wr_ptr), .buf_full(buf_full),
        .loss_irq(loss_irq));

    always @(posedge clk) begin
        if (cmd_valid && cmd_ack && n_cmds < 64) begin
            log_addr[n_cmds] <= cmd_addr;
            log_len[n_cmds]  <= cmd_len;
            n_cmds <= n_cmds + 1;
        end
        if (wr_valid && wr_ready && n_beats < 256) begin
            log_data[n_beats] <= wr_data;
            log_last[n_beats] <= wr_last;
            n_beats <= n_beats + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic chk_cmd(input string req, input int idx, input logic [ADDR_W-1:0] a, input int l);
        chk_eq({req, " addr"}, log_addr[idx], a);
        chk_eq({req, " len"}, log_len[idx], l);
    endtask

    task automatic t_reset();
        // R1
        chk_eq("R1 cmd_valid", cmd_valid, 0);
        chk_eq("R1 wr_valid", wr_valid, 0);
        chk_eq("R1 loss_irq", loss_irq, 0);
        chk_eq("R1 buf_full", buf_full, 0);
        chk_eq("R1 wr_ptr", wr_ptr, 0);
    endtask

    task automatic t_full_burst();
        int c0 = n_cmds, b0 = n_beats;
        pulse_start();
        for (int i = 0; i < 8; i++) push_word(32'hA000_0000 + i);
        idle(20);
        chk_eq("R2 cmd count", n_cmds - c0, 1);
        chk_cmd("R2", c0, 32'h1000, 8);
        chk_eq("R2 beat count", n_beats - b0, 8);
        for (int i = 0; i < 8; i++) begin
            chk_eq("R2 beat data", log_data[b0+i], 32'hA000_0000 + i);
            chk_eq("R2 beat last", log_last[b0+i], (i == 7) ? 1 : 0);
        end
        chk_eq("R9 wr_ptr after burst", wr_ptr, 32);
    endtask

    task automatic t_flush();
        int c0 = n_cmds, b0 = n_beats;
        for (int i = 0; i < 3; i++) push_word(32'hB000_0000 + i);
        idle(5);
        chk_eq("R3 no cmd before frame end", n_cmds - c0, 0);
        pulse_end();
        idle(15);
        chk_cmd("R3", c0, 32'h1020, 3);
        chk_eq("R3 last on third beat", log_last[b0+2], 1);
        chk_eq("R3 wr_ptr", wr_ptr, 44);
    endtask

    task automatic t_wrap();
        int c0 = n_cmds;
        rd_ptr = 9'd44;
        pulse_start();
        for (int i = 0; i < 15; i++) push_word(32'hC000_0000 + i);
        pulse_end();
        idle(20);
        chk_eq("R4 cmd count", n_cmds - c0, 3);
        chk_cmd("R2 first", c0, 32'h102C, 8);
        chk_cmd("R4 close at end", c0+1, 32'h104C, 5);
        chk_cmd("R4 restart at base", c0+2, 32'h1000, 2);
        chk_eq("R4 wr_ptr lap", wr_ptr, 9'h108);
    endtask

    task automatic t_limit();
        int c0, b0;
        rd_ptr = 9'h108;
        wr_ready = 1'b0;
        c0 = n_cmds; b0 = n_beats;
        pulse_start();
        for (int i = 0; i < 16; i++) push_word(32'hD000_0000 + i);
        idle(10);
        chk_eq("R5 two cmds outstanding", n_cmds - c0, 2);
        chk_eq("R5 no beats while stalled", n_beats - b0, 0);
        chk_cmd("R5 first", c0, 32'h1008, 8);
        chk_cmd("R5 second", c0+1, 32'h1028, 8);
        push_word(32'hD000_0010);
        chk_eq("R7 loss pulse slots busy", loss_irq, 1);
        @(negedge clk);
        chk_eq("R7 loss one cycle", loss_irq, 0);
        wr_ready = 1'b1;
        idle(30);
        chk_eq("R5 beats drained", n_beats - b0, 16);
        chk_eq("R5 beat 16 data", log_data[b0+15], 32'hD000_000F);
        chk_eq("R5 beat 8 last", log_last[b0+7], 1);
        chk_eq("R9 wr_ptr", wr_ptr, 9'h148);
        push_word(32'hD000_0011);
        chk_eq("R8 no second pulse", loss_irq, 0);
        idle(10);
        chk_eq("R8 still discarding", n_cmds - c0, 2);
        pulse_start();
        push_word(32'hE000_0000);
        pulse_end();
        idle(15);
        chk_eq("R8 resumes", n_cmds - c0, 3);
        chk_cmd("R8 resumed", c0+2, 32'h1048, 1);
    endtask

    task automatic t_ring_full();
        int c0 = n_cmds;
        idle(1);
        chk_eq("R6 full at 28 free", buf_full, 1);
        pulse_start();
        push_word(32'hF000_0000);
        chk_eq("R7 loss when ring full", loss_irq, 1);
        pulse_end();
        idle(10);
        chk_eq("R7 no cmd from dropped word", n_cmds - c0, 0);
        rd_ptr = 9'h14C;
        idle(1);
        chk_eq("R6 not full after read", buf_full, 0);
        pulse_start();
        push_word(32'hA100_0000);
        push_word(32'hA100_0001);
        pulse_end();
        idle(15);
        chk_cmd("R6 write after space", c0, 32'h104C, 2);
        chk_eq("R9 wr_ptr final", wr_ptr, 9'h154);
    endtask

    bit done = 1'b0;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_full_burst();
        t_flush();
        t_wrap();
        t_limit();
        t_ring_full();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule